// File: doc/BRIEF.md
# Edge-Interrupt GPIO Bank Controller

This block is a register-mapped controller for one bank of up to 32 general-purpose lines. The lines are grouped into four ports of eight lines each. A 32-bit register bus reaches the output-enable, output-value, line-level and pending-event registers. The bus is an address, a write strobe, write data and combinational read data. Each line drives an output value and an output enable. Each line's input passes through a two-stage synchronizer before the block uses it.

Each line carries a 2-bit interrupt mode. The same field chooses the edge to watch and enables the line, so code 0 turns the line off. Detected edges latch into a pending register, and software clears that register by writing ones. One interrupt output exists per CPU. Each has its own line-enable mask, which lets different lines go to different CPUs. A build-time layout switch picks the byte-lane order of the ports inside each register word.

Top module: `gpio_edge_bank`

## Requirements
- R1: A direction bit of 1 turns on `gpio_oe_o` for that line and drives `gpio_o` from the output-value register. A bit of 0 leaves the line as an input. Direction is at 0x08 and output value at 0x0C.
- R2: In normal layout (`PORT_REV`=0), a line `l` on port `p=l/8`, pin `q=l%8`, sits at bit `8*(3-p)+q` of the 1-bit registers. So port A is the top byte. The mode word at 0x14 holds port A in bits 31:16 and port B in bits 15:0. The mode word at 0x18 holds port C in bits 31:16 and port D in bits 15:0. Each pin takes bits `2q+1:2q` of its half.
- R3: In reversed layout (`PORT_REV`=1), line `l` sits at bit `l` of the 1-bit registers. The mode word at 0x14 holds port B in bits 31:16 and port A in bits 15:0. The mode word at 0x18 holds port D high and port C low.
- R4: A read of 0x0C returns the pin levels after two clock edges of synchronization. A level applied to `gpio_i` shows up after the second rising edge and not after the first.
- R5: The mode codes are 0 off, 1 falling, 2 rising and 3 both. A selected edge sets the line's pending bit at 0x10 on the third rising edge after the pin changes. An edge that is not selected, or any edge on a line in mode 0, leaves the pending bit clear.
- R6: A write to 0x10 clears each pending bit written as 1. Bits written as 0 keep their value.
- R7: When a new edge and a clearing write hit the same bit on the same clock edge, the bit stays set.
- R8: `irq_o[c]` is registered and is high one cycle after some line has a pending bit, a nonzero mode and a set mask bit for CPU `c`. Setting a line's mode to 0 hides its pending bit from the interrupt while the bit stays readable.
- R9: The line-enable mask of CPU `c` is at `MASK_BASE+4*c` and uses the 1-bit layout. Reset sets it to all ones. A 0 bit stops that line from raising `irq_o[c]`.
- R10: Reset clears direction, output value, pending and mode registers, and drives every `irq_o` low.
- R11: Lines at or above `N_LINES` read as 0 in every register and ignore writes.
- R12: Offset 0x00 and every unmapped offset read as 0, and writes to them change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address of the register |
| we_i | input | 1 | Write strobe, sampled on the rising clock edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| gpio_i | input | N_LINES | Line input levels, asynchronous |
| gpio_o | output | N_LINES | Line output values |
| gpio_oe_o | output | N_LINES | Line output enables |
| irq_o | output | N_CPU | Interrupt request per CPU |

## Verification
The hardest case to reach from the ports is a clearing write that lands on the same clock edge as a new edge on the same line. The pin change takes three register stages to reach the pending bit, so the bench changes the pin on a falling clock edge. It then lets two rising edges pass and raises the clearing write just before the third. The line is already pending before this, so a design where clear wins reads back 0 at that point, while a correct one reads back 1. A second design instance built with the reversed layout checks that the lane mapping follows the parameter.

// File: rtl/gpio_edge_bank_pkg.sv
package gpio_edge_bank_pkg;

  localparam int unsigned BUS_W      = 32;
  localparam int unsigned PORT_LINES = 8;

  localparam int unsigned OFS_FUNC    = 'h00;
  localparam int unsigned OFS_DIR     = 'h08;
  localparam int unsigned OFS_DATA    = 'h0C;
  localparam int unsigned OFS_PEND    = 'h10;
  localparam int unsigned OFS_MODE_LO = 'h14;
  localparam int unsigned OFS_MODE_HI = 'h18;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_FALL = 2'd1,
    MODE_RISE = 2'd2,
    MODE_BOTH = 2'd3
  } edge_mode_e;

  // bit of a line in a one-bit-per-line register
  function automatic logic [4:0] bit_pos(int line, bit rev);
    int prt;
    int pin;
    prt = line / PORT_LINES;
    pin = line % PORT_LINES;
    if (rev) return 5'(line);
    return 5'(PORT_LINES * (3 - prt) + pin);
  endfunction

  // bit of a line's mode field in the 64-bit pair {0x18, 0x14}
  function automatic logic [5:0] mode_pos(int line, bit rev);
    int prt;
    int pin;
    int half;
    prt  = line / PORT_LINES;
    pin  = line % PORT_LINES;
    half = rev ? (prt % 2) : (1 - (prt % 2));
    return 6'(32 * (prt / 2) + 16 * half + 2 * pin);
  endfunction

endpackage

// File: rtl/gpio_edge_bank_sync.sv
module gpio_edge_bank_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;

endmodule

// File: rtl/gpio_edge_bank_detect.sv
module gpio_edge_bank_detect #(
  parameter int N_LINES = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_LINES-1:0]      level_i,
  input  logic [N_LINES-1:0][1:0] mode_i,
  output logic [N_LINES-1:0]      hit_o
);

  logic [N_LINES-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= level_i;
  end

  for (genvar l = 0; l < N_LINES; l++) begin : g_line
    logic rise;
    logic fall;
    assign rise     = level_i[l] & ~prev_q[l];
    assign fall     = ~level_i[l] & prev_q[l];
    // mode bit 1 selects rising, bit 0 selects falling
    assign hit_o[l] = (mode_i[l][1] & rise) | (mode_i[l][0] & fall);
  end

endmodule

// File: rtl/gpio_edge_bank_route.sv
module gpio_edge_bank_route #(
  parameter int N_LINES   = 32,
  parameter int N_CPU     = 2,
  parameter bit CPU_ROUTE = 1'b1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [N_LINES-1:0]             pend_i,
  input  logic [N_CPU-1:0][N_LINES-1:0]  mask_i,
  output logic [N_CPU-1:0]               irq_o
);

  logic [N_CPU-1:0] req;
  logic [N_CPU-1:0] irq_q;

  for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
    if (CPU_ROUTE) begin : g_masked
      assign req[c] = |(pend_i & mask_i[c]);
    end else begin : g_flat
      logic [N_LINES-1:0] unused_mask;
      assign unused_mask = mask_i[c];
      assign req[c]      = |pend_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= '0;
    else         irq_q <= req;
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_edge_bank_pkg::*;
#(
  parameter int N_LINES   = 32,
  parameter int N_CPU     = 2,
  parameter bit CPU_ROUTE = 1'b1,
  parameter bit PORT_REV  = 1'b0,
  parameter int ADDR_W    = 8,
  parameter int MASK_BASE = 'h20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               we_i,
  input  logic [BUS_W-1:0]   wdata_i,
  output logic [BUS_W-1:0]   rdata_o,
  input  logic [N_LINES-1:0] gpio_i,
  output logic [N_LINES-1:0] gpio_o,
  output logic [N_LINES-1:0] gpio_oe_o,
  output logic [N_CPU-1:0]   irq_o
);

  localparam int CPU_W     = (N_CPU > 1) ? $clog2(N_CPU) : 1;
  localparam int MASK_SPAN = 4 * N_CPU;
  localparam int MAX_LINES = 4 * PORT_LINES;

  logic [N_LINES-1:0]            dir_q, dout_q, stat_q;
  logic [N_LINES-1:0][1:0]       mode_q;
  logic [N_CPU-1:0][N_LINES-1:0] mask_q;

  logic [N_LINES-1:0]            pin_sync, edge_hit, mode_en, stat_clr, pend_live;
  logic [N_LINES-1:0]            wr_line, mode_hi;
  logic [N_LINES-1:0][1:0]       wr_mode;

  logic [BUS_W-1:0]              dir_w, data_w, stat_w;
  logic [2*BUS_W-1:0]            mode_w;
  logic [N_CPU-1:0][BUS_W-1:0]   mask_w;

  logic                          wr_dir, wr_data, wr_pend, wr_mode_lo, wr_mode_hi;
  logic                          is_mask;
  logic [ADDR_W-1:0]             mask_off;
  logic [CPU_W-1:0]              cpu_idx;
  logic [N_CPU-1:0]              wr_mask;

  // ---- lane mapping between line index and bus bit -------------------------
  for (genvar l = 0; l < MAX_LINES; l++) begin : g_lane
    localparam logic [4:0] BP = bit_pos(l, PORT_REV);
    localparam logic [5:0] MP = mode_pos(l, PORT_REV);
    if (l < N_LINES) begin : g_live
      assign dir_w[BP]       = dir_q[l];
      assign data_w[BP]      = pin_sync[l];
      assign stat_w[BP]      = stat_q[l];
      assign mode_w[MP +: 2] = mode_q[l];
      assign wr_line[l]      = wdata_i[BP];
      assign wr_mode[l]      = wdata_i[MP[4:0] +: 2];
      assign mode_hi[l]      = MP[5];
      assign mode_en[l]      = |mode_q[l];
      for (genvar c = 0; c < N_CPU; c++) begin : g_mask
        assign mask_w[c][BP] = mask_q[c][l];
      end
    end else begin : g_void
      assign dir_w[BP]       = 1'b0;
      assign data_w[BP]      = 1'b0;
      assign stat_w[BP]      = 1'b0;
      assign mode_w[MP +: 2] = 2'b00;
      for (genvar c = 0; c < N_CPU; c++) begin : g_mask
        assign mask_w[c][BP] = 1'b0;
      end
    end
  end

  // ---- address decode ------------------------------------------------------
  assign wr_dir     = we_i && (addr_i == ADDR_W'(OFS_DIR));
  assign wr_data    = we_i && (addr_i == ADDR_W'(OFS_DATA));
  assign wr_pend    = we_i && (addr_i == ADDR_W'(OFS_PEND));
  assign wr_mode_lo = we_i && (addr_i == ADDR_W'(OFS_MODE_LO));
  assign wr_mode_hi = we_i && (addr_i == ADDR_W'(OFS_MODE_HI));

  assign mask_off = addr_i - ADDR_W'(MASK_BASE);
  assign is_mask  = (addr_i >= ADDR_W'(MASK_BASE)) &&
                    (mask_off < ADDR_W'(MASK_SPAN)) &&
                    (mask_off[1:0] == 2'b00);
  assign cpu_idx  = mask_off[CPU_W+1:2];

  for (genvar c = 0; c < N_CPU; c++) begin : g_wr_mask
    assign wr_mask[c] = we_i && is_mask && (cpu_idx == CPU_W'(c));
  end

  assign stat_clr  = wr_pend ? wr_line : '0;
  assign pend_live = stat_q & mode_en;

  // ---- read mux ------------------------------------------------------------
  always_comb begin
    rdata_o = '0;
    if      (addr_i == ADDR_W'(OFS_DIR))     rdata_o = dir_w;
    else if (addr_i == ADDR_W'(OFS_DATA))    rdata_o = data_w;
    else if (addr_i == ADDR_W'(OFS_PEND))    rdata_o = stat_w;
    else if (addr_i == ADDR_W'(OFS_MODE_LO)) rdata_o = mode_w[BUS_W-1:0];
    else if (addr_i == ADDR_W'(OFS_MODE_HI)) rdata_o = mode_w[2*BUS_W-1:BUS_W];
    else if (is_mask)                        rdata_o = mask_w[cpu_idx];
  end

  // ---- registers -----------------------------------------------------------
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      dout_q <= '0;
      stat_q <= '0;
      mode_q <= '0;
      mask_q <= '1;
    end else begin
      if (wr_dir)  dir_q  <= wr_line;
      if (wr_data) dout_q <= wr_line;
      // new edge wins over a same-cycle clear
      stat_q <= (stat_q & ~stat_clr) | edge_hit;
      for (int l = 0; l < N_LINES; l++) begin
        if ((wr_mode_lo && !mode_hi[l]) || (wr_mode_hi && mode_hi[l]))
          mode_q[l] <= wr_mode[l];
      end
      for (int c = 0; c < N_CPU; c++) begin
        if (wr_mask[c]) mask_q[c] <= wr_line;
      end
    end
  end

  assign gpio_o    = dout_q;
  assign gpio_oe_o = dir_q;

  // ---- datapath ------------------------------------------------------------
  gpio_edge_bank_sync #(
    .WIDTH (N_LINES)
  ) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (gpio_i),
    .sync_o  (pin_sync)
  );

  gpio_edge_bank_detect #(
    .N_LINES (N_LINES)
  ) u_detect (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_i (pin_sync),
    .mode_i  (mode_q),
    .hit_o   (edge_hit)
  );

  gpio_edge_bank_route #(
    .N_LINES   (N_LINES),
    .N_CPU     (N_CPU),
    .CPU_ROUTE (CPU_ROUTE)
  ) u_route (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pend_i (pend_live),
    .mask_i (mask_q),
    .irq_o  (irq_o)
  );

endmodule

// File: rtl/gpio_edge_bank_chk.sv
module gpio_edge_bank_chk
  import gpio_edge_bank_pkg::*;
#(
  parameter int N_LINES = 32,
  parameter int N_CPU   = 2,
  parameter int ADDR_W  = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               we_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [N_LINES-1:0] gpio_oe_o,
  input logic [N_CPU-1:0]   irq_o,
  input logic [N_LINES-1:0] stat_q,
  input logic [N_LINES-1:0] stat_clr,
  input logic [N_LINES-1:0] edge_hit,
  input logic [N_LINES-1:0] mode_en
);

  assert_oe_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == ADDR_W'(OFS_DIR)) |=> $stable(gpio_oe_o));

  assert_no_silent_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_clr == '0) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  assert_set_beats_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_hit != '0) |=> ((stat_q & $past(edge_hit)) == $past(edge_hit)));

  assert_irq_has_source_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o != '0) |-> $past((stat_q & mode_en) != '0));

  always @(posedge clk_i) begin
    if (rst_ni) begin
      assert_off_line_quiet_R5: assert ((edge_hit & ~mode_en) == '0)
        else $error("edge reported on a line in mode 0");
    end
  end

endmodule

bind gpio_edge_bank gpio_edge_bank_chk #(
  .N_LINES (N_LINES),
  .N_CPU   (N_CPU),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .gpio_oe_o (gpio_oe_o),
  .irq_o     (irq_o),
  .stat_q    (stat_q),
  .stat_clr  (stat_clr),
  .edge_hit  (edge_hit),
  .mode_en   (mode_en)
);

// File: tb/gpio_edge_bank_tb.sv
module gpio_edge_bank_tb;

  localparam int NL = 28;
  localparam int NV = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  // normal-layout DUT, 28 lines
  logic [7:0]    addr = '0;
  logic          we = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NL-1:0] gpio_in = '0;
  logic [NL-1:0] gpio_out, gpio_oe;
  logic [1:0]    irq;

  // reversed-layout DUT, 32 lines
  logic [7:0]    r_addr = '0;
  logic          r_we = 1'b0;
  logic [31:0]   r_wdata = '0;
  logic [31:0]   r_rdata;
  logic [31:0]   r_gpio_in = '0;
  logic [31:0]   r_gpio_out, r_gpio_oe;
  logic [1:0]    r_irq;

  gpio_edge_bank #(.N_LINES(NL), .N_CPU(2), .PORT_REV(1'b0)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .gpio_i(gpio_in), .gpio_o(gpio_out), .gpio_oe_o(gpio_oe),
    .irq_o(irq));

  gpio_edge_bank #(.N_LINES(32), .N_CPU(2), .PORT_REV(1'b1)) u_dut_rev (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(r_addr), .we_i(r_we), .wdata_i(r_wdata),
    .rdata_o(r_rdata), .gpio_i(r_gpio_in), .gpio_o(r_gpio_out), .gpio_oe_o(r_gpio_oe),
    .irq_o(r_irq));

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // vector table: write, read back same address, observe outputs
  localparam logic [7:0]    V_ADDR [NV] = '{8'h08, 8'h08, 8'h08, 8'h0C, 8'h0C, 8'h08, 8'h00};
  localparam logic [31:0]   V_WD   [NV] = '{32'h000000FF, 32'hFF000000, 32'h00FF0000,
                                            32'h0000A500, 32'h12000000, 32'hFFFFFFFF, 32'hFFFFFFFF};
  localparam logic [31:0]   V_RD   [NV] = '{32'h0000000F, 32'hFF000000, 32'h00FF0000,
                                            32'h0, 32'h0, 32'hFFFFFF0F, 32'h0};
  localparam logic [NL-1:0] V_OE   [NV] = '{28'hF000000, 28'h00000FF, 28'h000FF00,
                                            28'h000FF00, 28'h000FF00, 28'hFFFFFFF, 28'hFFFFFFF};
  localparam logic [NL-1:0] V_OUT  [NV] = '{28'h0, 28'h0, 28'h0,
                                            28'h0A50000, 28'h0000012, 28'h0000012, 28'h0000012};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wr_r(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    r_addr = a; r_wdata = d; r_we = 1'b1;
    @(negedge clk);
    r_we = 1'b0;
  endtask

  task automatic rd_r(input logic [7:0] a, output logic [31:0] d);
    r_addr = a;
    #1;
    d = r_rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    ticks(3);
    rst_n = 1'b1;
    ticks(1);

    // R10 reset state
    rd(8'h08, r); chk("R10 dir", r, 32'h0);
    rd(8'h10, r); chk("R10 pend", r, 32'h0);
    rd(8'h14, r); chk("R10 mode lo", r, 32'h0);
    rd(8'h18, r); chk("R10 mode hi", r, 32'h0);
    chk("R10 oe", 32'(gpio_oe), 32'h0);
    chk("R10 irq", 32'(irq), 32'h0);
    // R9 masks reset to ones, R11 absent lines read 0
    rd(8'h20, r); chk("R9 mask0 reset", r, 32'hFFFFFF0F);
    rd(8'h24, r); chk("R9 mask1 reset", r, 32'hFFFFFF0F);

    // R1 R2 R11 R12 table walk
    for (int i = 0; i < NV; i++) begin
      wr(V_ADDR[i], V_WD[i]);
      rd(V_ADDR[i], r);
      chk($sformatf("R2 R11 R12 vec%0d read", i), r, V_RD[i]);
      chk($sformatf("R1 vec%0d oe", i), 32'(gpio_oe), 32'(V_OE[i]));
      chk($sformatf("R1 vec%0d out", i), 32'(gpio_out), 32'(V_OUT[i]));
    end
    rd(8'h30, r); chk("R12 unmapped", r, 32'h0);

    // R4 two-stage sync
    gpio_in[0] = 1'b1;
    ticks(1); rd(8'h0C, r); chk("R4 after one edge", r, 32'h0);
    ticks(1); rd(8'h0C, r); chk("R4 after two edges", r, 32'h01000000);

    // R5 rising on line 0 (0x14 bits 17:16)
    wr(8'h14, 32'h00020000);
    gpio_in[0] = 1'b0; ticks(4);
    rd(8'h10, r); chk("R5 rise-mode ignores fall", r, 32'h0);
    gpio_in[0] = 1'b1; ticks(4);
    rd(8'h10, r); chk("R5 rise latched", r, 32'h01000000);
    chk("R8 irq both cpus", 32'(irq), 32'h3);

    // R6 write-one-to-clear
    wr(8'h10, 32'h0);
    rd(8'h10, r); chk("R6 zero write keeps", r, 32'h01000000);
    wr(8'h10, 32'h01000000);
    rd(8'h10, r); chk("R6 one write clears", r, 32'h0);
    chk("R8 irq still registered", 32'(irq), 32'h3);
    ticks(1);
    chk("R8 irq drops next cycle", 32'(irq), 32'h0);

    // R5 falling on line 8 (0x14 bits 1:0)
    wr(8'h14, 32'h00020001);
    gpio_in[8] = 1'b1; ticks(4);
    rd(8'h10, r); chk("R5 fall-mode ignores rise", r, 32'h0);
    gpio_in[8] = 1'b0; ticks(4);
    rd(8'h10, r); chk("R5 fall latched", r, 32'h00010000);
    wr(8'h10, 32'h00010000);

    // R5 both on line 16 (0x18 bits 17:16)
    wr(8'h18, 32'h00030000);
    gpio_in[16] = 1'b1; ticks(4);
    rd(8'h10, r); chk("R5 both rise", r, 32'h00000100);
    wr(8'h10, 32'h00000100);
    gpio_in[16] = 1'b0; ticks(4);
    rd(8'h10, r); chk("R5 both fall", r, 32'h00000100);
    wr(8'h10, 32'h00000100);

    // R5 mode 0 on line 24
    gpio_in[24] = 1'b1; ticks(4);
    rd(8'h10, r); chk("R5 off line rise", r, 32'h0);
    gpio_in[24] = 1'b0; ticks(4);
    rd(8'h10, r); chk("R5 off line fall", r, 32'h0);
    chk("R5 off line irq", 32'(irq), 32'h0);

    // R9 CPU1 mask blocks
    wr(8'h24, 32'h0);
    rd(8'h24, r); chk("R9 mask1 readback", r, 32'h0);
    gpio_in[16] = 1'b1; ticks(4);
    chk("R9 only cpu0 irq", 32'(irq), 32'h1);
    wr(8'h24, 32'hFFFFFFFF);
    ticks(1);
    chk("R9 cpu1 restored", 32'(irq), 32'h3);

    // R8 mode 0 hides a pending line
    wr(8'h18, 32'h0);
    ticks(1);
    rd(8'h10, r); chk("R8 pending kept", r, 32'h00000100);
    chk("R8 irq gated by mode", 32'(irq), 32'h0);

    // R7 set beats same-cycle clear, line 0 in both mode
    wr(8'h10, 32'hFFFFFFFF);
    wr(8'h14, 32'h00030000);
    gpio_in[0] = 1'b0; ticks(4);
    rd(8'h10, r); chk("R7 precondition", r, 32'h01000000);
    ticks(1);
    gpio_in[0] = 1'b1;
    ticks(2);
    addr = 8'h10; wdata = 32'h01000000; we = 1'b1;
    ticks(1);
    we = 1'b0;
    rd(8'h10, r); chk("R7 set wins", r, 32'h01000000);
    wr(8'h10, 32'h01000000);
    rd(8'h10, r); chk("R6 later clear", r, 32'h0);

    // R3 reversed layout
    rd_r(8'h20, r); chk("R3 R9 rev mask reset", r, 32'hFFFFFFFF);
    wr_r(8'h08, 32'h000000FF);
    chk("R3 rev oe lines 0-7", r_gpio_oe, 32'h000000FF);
    wr_r(8'h14, 32'h00020000);
    r_gpio_in[8] = 1'b1; ticks(4);
    rd_r(8'h10, r); chk("R3 rev port B pending", r, 32'h00000100);
    chk("R3 rev irq", 32'(r_irq), 32'h3);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule